// File: doc/BRIEF.md
# Double-Buffer Frame Rendezvous Controller

This block paces a frame writer and a frame reader that share two frame buffers in external memory. Each side has its own buffer index and its own base address. When a side finishes a frame, it stops, works out the base address of the buffer it will use next, and then parks. A parked side raises its continue line on every cycle until the other side has also parked. Both sides then leave the rendezvous on the same cycle. Each swaps its buffer index, and both start the next frame. The writer always moves on to a fresh buffer and the reader always takes the buffer that was just filled. So neither side can run a frame ahead of the other, and the two sides never use the same buffer at once.

Both sides run on the memory clock. The block has no data stream, so it uses no valid/ready pairs. Every pin is a plain level or a single-cycle strobe. A frame covers `H_PIX * V_LINES` words, and buffer 1 sits that many words above buffer 0. A watchdog on each side flags a side that has been parked for longer than two frame periods, counted in words.

Top module: `dbuf_rendezvous`

## Requirements
- R1: While `rst_n` is low and right after reset: `wr_go`=1, `wr_cont`=0, `wr_idx`=0, `wr_base`=BASE_ADDR, `rd_go`=0, `rd_cont`=1, `rd_idx`=1, `rd_base`=BASE_ADDR+FRAME_WORDS, and both timeout flags are 0.
- R2: A done strobe that is sampled high while the side's go is 1 drops that side's go from the next cycle on. The side then spends one cycle with go=0 and cont=0 while it computes its next base, and raises cont on the cycle after that.
- R3: A parked side keeps its cont output high on every cycle until the cycle on which both sides' cont lines are high together.
- R4: On the clock edge after both cont lines are high together, both cont lines fall. One cycle after that, both go outputs rise together. If the strobes arrive at edges dw and dr, both sides run again after edge max(dw,dr)+3.
- R5: When a side resumes, its idx has inverted, and its base equals BASE_ADDR + idx*FRAME_WORDS, where FRAME_WORDS = H_PIX*V_LINES. While the side runs, idx and base do not change.
- R6: Whenever both go outputs are 1, `wr_idx` differs from `rd_idx`.
- R7: A done strobe that arrives while a side's go is 0 has no effect on the timing, idx or base of that side.
- R8: After reset the reader stays parked, with go=0 and cont=1, until the writer completes its first frame. The reader then starts on buffer 0 and the writer moves on to buffer 1.
- R9: A side's timeout flag rises once it has been parked for more than WAIT_LIMIT = 2*FRAME_WORDS consecutive cycles: after reset, the reader's flag rises after edge WAIT_LIMIT (edges counted from 0). The flag stays high until reset, even after the rendezvous completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_done | input | 1 | Writer frame-complete strobe |
| rd_done | input | 1 | Reader frame-complete strobe |
| wr_go | output | 1 | Writer may stream its current frame |
| rd_go | output | 1 | Reader may stream its current frame |
| wr_cont | output | 1 | Writer parked at the frame boundary, signalling the reader |
| rd_cont | output | 1 | Reader parked at the frame boundary, signalling the writer |
| wr_idx | output | 1 | Writer's current buffer index |
| rd_idx | output | 1 | Reader's current buffer index |
| wr_base | output | ADDR_W | Writer's current buffer base address |
| rd_base | output | ADDR_W | Reader's current buffer base address |
| wr_timeout | output | 1 | Sticky flag: writer parked too long |
| rd_timeout | output | 1 | Sticky flag: reader parked too long |

## Verification
The properties require the done strobes to be synchronous to `clk`, and they require reset to have been applied once before checking starts. They make no assumption about when the strobes arrive or how long they last. A strobe may come while a side is computing or parked, and the properties still have to hold. The stimulus drives every input half a cycle away from the active edge. It sweeps the two strobe arrival times over a small grid that covers the writer first, the reader first and both together. It also injects extra strobes while a side is not running, and it holds one side back past the watchdog limit.

// File: rtl/dbuf_rendezvous_pkg.sv
package dbuf_rendezvous_pkg;
  typedef enum logic [1:0] {
    SIDE_RUN    = 2'd0,
    SIDE_CALC   = 2'd1,
    SIDE_WAIT   = 2'd2,
    SIDE_RESUME = 2'd3
  } side_state_t;
endpackage

// File: rtl/dbuf_side.sv
module dbuf_side
  import dbuf_rendezvous_pkg::*;
#(
  parameter int FRAME_WORDS = 420000,
  parameter int BASE_ADDR   = 0,
  parameter int ADDR_W      = 20,
  parameter bit START_PARKED = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic              peer_cont,
  output logic              go,
  output logic              cont,
  output logic              idx,
  output logic [ADDR_W-1:0] base
);
  localparam logic [ADDR_W-1:0] BUF0_BASE = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] BUF1_BASE = ADDR_W'(BASE_ADDR + FRAME_WORDS);

  side_state_t       st_q;
  logic              fin_q;
  logic              idx_q;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] next_base_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= START_PARKED ? SIDE_WAIT : SIDE_RUN;
      fin_q       <= START_PARKED;
      idx_q       <= START_PARKED;
      base_q      <= START_PARKED ? BUF1_BASE : BUF0_BASE;
      next_base_q <= START_PARKED ? BUF0_BASE : BUF1_BASE;
    end else begin
      unique case (st_q)
        SIDE_RUN: begin
          if (done) begin
            fin_q <= 1'b1;
            st_q  <= SIDE_CALC;
          end
        end
        SIDE_CALC: begin
          next_base_q <= idx_q ? BUF0_BASE : BUF1_BASE;
          st_q        <= SIDE_WAIT;
        end
        SIDE_WAIT: begin
          if (fin_q && peer_cont) st_q <= SIDE_RESUME;
        end
        SIDE_RESUME: begin
          idx_q  <= ~idx_q;
          base_q <= next_base_q;
          fin_q  <= 1'b0;
          st_q   <= SIDE_RUN;
        end
        default: st_q <= SIDE_RUN;
      endcase
    end
  end

  assign go   = (st_q == SIDE_RUN);
  assign cont = (st_q == SIDE_WAIT);
  assign idx  = idx_q;
  assign base = base_q;
endmodule

// File: rtl/dbuf_wait_watchdog.sv
module dbuf_wait_watchdog #(
  parameter int LIMIT = 840000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic parked,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             exp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      if (!parked) cnt_q <= '0;
      else if (cnt_q != CNT_W'(LIMIT)) cnt_q <= cnt_q + 1'b1;
      if (parked && cnt_q == CNT_W'(LIMIT)) exp_q <= 1'b1;
    end
  end

  assign expired = exp_q;
endmodule

// File: rtl/dbuf_rendezvous.sv
module dbuf_rendezvous #(
  parameter int H_PIX     = 800,
  parameter int V_LINES   = 525,
  parameter int BASE_ADDR = 0,
  parameter int ADDR_W    = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_done,
  input  logic              rd_done,
  output logic              wr_go,
  output logic              rd_go,
  output logic              wr_cont,
  output logic              rd_cont,
  output logic              wr_idx,
  output logic              rd_idx,
  output logic [ADDR_W-1:0] wr_base,
  output logic [ADDR_W-1:0] rd_base,
  output logic              wr_timeout,
  output logic              rd_timeout
);
  localparam int FRAME_WORDS = H_PIX * V_LINES;
  localparam int WAIT_LIMIT  = 2 * FRAME_WORDS;
  localparam int N_SIDES     = 2;

  logic [N_SIDES-1:0] done_v, go_v, cont_v, idx_v, tmo_v;
  logic [ADDR_W-1:0]  base_v [N_SIDES];

  assign done_v = {rd_done, wr_done};

  for (genvar g = 0; g < N_SIDES; g++) begin : g_side
    dbuf_side #(
      .FRAME_WORDS (FRAME_WORDS),
      .BASE_ADDR   (BASE_ADDR),
      .ADDR_W      (ADDR_W),
      .START_PARKED(g == 1)
    ) u_side (
      .clk      (clk),
      .rst_n    (rst_n),
      .done     (done_v[g]),
      .peer_cont(cont_v[N_SIDES-1-g]),
      .go       (go_v[g]),
      .cont     (cont_v[g]),
      .idx      (idx_v[g]),
      .base     (base_v[g])
    );

    dbuf_wait_watchdog #(
      .LIMIT(WAIT_LIMIT)
    ) u_wdog (
      .clk    (clk),
      .rst_n  (rst_n),
      .parked (cont_v[g]),
      .expired(tmo_v[g])
    );
  end

  assign wr_go      = go_v[0];
  assign rd_go      = go_v[1];
  assign wr_cont    = cont_v[0];
  assign rd_cont    = cont_v[1];
  assign wr_idx     = idx_v[0];
  assign rd_idx     = idx_v[1];
  assign wr_base    = base_v[0];
  assign rd_base    = base_v[1];
  assign wr_timeout = tmo_v[0];
  assign rd_timeout = tmo_v[1];
endmodule

// File: rtl/dbuf_rendezvous_chk.sv
module dbuf_rendezvous_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_done,
  input logic rd_done,
  input logic wr_go,
  input logic rd_go,
  input logic wr_cont,
  input logic rd_cont,
  input logic wr_idx,
  input logic rd_idx,
  input logic wr_timeout,
  input logic rd_timeout
);
  AST_WR_DONE_HALTS: assert property (@(posedge clk) disable iff (!rst_n) (wr_done && wr_go) |=> (!wr_go && !wr_cont)); // R2
  AST_RD_DONE_HALTS: assert property (@(posedge clk) disable iff (!rst_n) (rd_done && rd_go) |=> (!rd_go && !rd_cont)); // R2
  AST_WR_CONT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (wr_cont && !rd_cont) |=> wr_cont); // R3
  AST_RD_CONT_HELD: assert property (@(posedge clk) disable iff (!rst_n) (rd_cont && !wr_cont) |=> rd_cont); // R3
  AST_JOINT_WR_RESUME: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_go) |-> $rose(rd_go)); // R4
  AST_JOINT_RD_RESUME: assert property (@(posedge clk) disable iff (!rst_n) $rose(rd_go) |-> $rose(wr_go)); // R4
  AST_WR_IDX_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (wr_go && $past(wr_go)) |-> $stable(wr_idx)); // R5
  AST_SPLIT_BUFFERS: assert property (@(posedge clk) disable iff (!rst_n) (wr_go && rd_go) |-> (wr_idx != rd_idx)); // R6
  AST_WR_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n) wr_timeout |=> wr_timeout); // R9
  AST_RD_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n) rd_timeout |=> rd_timeout); // R9
endmodule

bind dbuf_rendezvous dbuf_rendezvous_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_done   (wr_done),
  .rd_done   (rd_done),
  .wr_go     (wr_go),
  .rd_go     (rd_go),
  .wr_cont   (wr_cont),
  .rd_cont   (rd_cont),
  .wr_idx    (wr_idx),
  .rd_idx    (rd_idx),
  .wr_timeout(wr_timeout),
  .rd_timeout(rd_timeout)
);

// File: tb/sim_dbuf_rendezvous.sv
module sim_dbuf_rendezvous;
  localparam int H   = 4;
  localparam int V   = 3;
  localparam int FW  = H * V;
  localparam int BA  = 16;
  localparam int AW  = 8;
  localparam int LIM = 2 * FW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, wr_done, rd_done;
  logic wr_go, rd_go, wr_cont, rd_cont, wr_idx, rd_idx, wr_timeout, rd_timeout;
  logic [AW-1:0] wr_base, rd_base;

  int  checks = 0;
  int  failures = 0;
  logic ew_idx, er_idx, ew_to, er_to;

  dbuf_rendezvous #(.H_PIX(H), .V_LINES(V), .BASE_ADDR(BA), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_done(wr_done), .rd_done(rd_done),
    .wr_go(wr_go), .rd_go(rd_go), .wr_cont(wr_cont), .rd_cont(rd_cont),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .wr_base(wr_base), .rd_base(rd_base),
    .wr_timeout(wr_timeout), .rd_timeout(rd_timeout)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] base_of(input logic i);
    return BA + (i ? FW : 0);
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // A reader already parked since reset is modelled as dr = -2.
  task automatic round(input int dw, input int dr, input bit extra);
    int  m;
    logic pw, pr;
    m  = (dw > dr) ? dw : dr;
    pw = ew_to;
    pr = er_to;
    for (int k = 0; k <= m + 4; k++) begin
      wr_done = (k == dw) || (extra && (k == dw + 1 || k == dw + 2));
      rd_done = (k == dr) || (extra && (k == dr + 1 || k == dr + 2));
      @(posedge clk);
      @(negedge clk);
      begin
        logic xw, xr;
        xw = (k >= m + 3) ? ~ew_idx : ew_idx;
        xr = (k >= m + 3) ? ~er_idx : er_idx;
        chk("R2", "wr_go", 32'(wr_go), 32'((k < dw) || (k >= m + 3)));
        chk("R2", "rd_go", 32'(rd_go), 32'((k < dr) || (k >= m + 3)));
        chk("R3", "wr_cont", 32'(wr_cont), 32'((k >= dw + 1) && (k <= m + 1)));
        chk("R3", "rd_cont", 32'(rd_cont), 32'((k >= dr + 1) && (k <= m + 1)));
        chk("R5", "wr_idx", 32'(wr_idx), 32'(xw));
        chk("R5", "rd_idx", 32'(rd_idx), 32'(xr));
        chk("R5", "wr_base", 32'(wr_base), base_of(xw));
        chk("R5", "rd_base", 32'(rd_base), base_of(xr));
        chk("R9", "wr_timeout", 32'(wr_timeout), 32'(pw || ((k >= dw + 2 + LIM) && (m - dw >= LIM))));
        chk("R9", "rd_timeout", 32'(rd_timeout), 32'(pr || ((k >= dr + 2 + LIM) && (m - dr >= LIM))));
        if (wr_go && rd_go) chk("R6", "idx differ", 32'(wr_idx != rd_idx), 32'd1);
        if (extra && k == m + 4) chk("R7", "stray strobe ignored go", 32'({wr_go, rd_go}), 32'd3);
      end
    end
    wr_done = 1'b0;
    rd_done = 1'b0;
    ew_idx = ~ew_idx;
    er_idx = ~er_idx;
    ew_to = pw || (m - dw >= LIM);
    er_to = pr || (m - dr >= LIM);
  endtask

  task automatic check_reset_state();
    chk("R1", "wr_go", 32'(wr_go), 32'd1);
    chk("R1", "wr_cont", 32'(wr_cont), 32'd0);
    chk("R1", "wr_idx", 32'(wr_idx), 32'd0);
    chk("R1", "wr_base", 32'(wr_base), 32'(BA));
    chk("R8", "rd_go", 32'(rd_go), 32'd0);
    chk("R1", "rd_cont", 32'(rd_cont), 32'd1);
    chk("R1", "rd_idx", 32'(rd_idx), 32'd1);
    chk("R1", "rd_base", 32'(rd_base), 32'(BA + FW));
    chk("R9", "timeouts clear", 32'({wr_timeout, rd_timeout}), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_done = 1'b0; rd_done = 1'b0;
    ew_idx = 1'b0; er_idx = 1'b1; ew_to = 1'b0; er_to = 1'b0;
    repeat (3) @(negedge clk);
    check_reset_state();
    rst_n = 1'b1;

    // R8 / R9: reader parked from reset; its watchdog fires after edge LIM.
    for (int k = 0; k <= LIM; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R9", "rd_timeout from reset", 32'(rd_timeout), 32'(k >= LIM));
      chk("R8", "reader parked", 32'({rd_go, rd_cont}), 32'b01);
      chk("R8", "writer running", 32'(wr_go), 32'd1);
    end
    er_to = 1'b1;

    // R8: first writer frame releases the reader onto buffer 0.
    round(0, -2, 1'b0);
    chk("R8", "reader buffer after first frame", 32'(rd_idx), 32'd0);
    chk("R9", "rd_timeout stays after rendezvous", 32'(rd_timeout), 32'd1);

    // R4 / R7: sweep of strobe arrival times, with stray strobes on alternate rounds.
    for (int dw = 0; dw <= 4; dw++)
      for (int dr = 0; dr <= 4; dr++)
        round(dw, dr, ((dw + dr) % 2) == 1);

    // R9: writer held at the boundary past the limit.
    round(0, LIM + 3, 1'b0);
    chk("R9", "wr_timeout raised", 32'(wr_timeout), 32'd1);

    // R1 / R9: reset clears the flags and restores the start state.
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_reset_state();
    ew_idx = 1'b0; er_idx = 1'b1; ew_to = 1'b0; er_to = 1'b0;
    rst_n = 1'b1;
    round(2, -2, 1'b1);
    round(1, 3, 1'b0);

    finish_run();
  end
endmodule